// File: doc/BRIEF.md
# Sample-Playback DMA Channel Sequencer

This block sequences one channel of a sample-playback sound generator. With its DMA enable high it loads a start address and a word count, and fetches 16-bit sample words through a request/acknowledge port. Each word is played as two bytes, the upper byte first. Each byte is held for a programmable number of clock-enable ticks. The channel raises an interrupt when a block starts and loops over the block for as long as it stays enabled. Mixing, digital-to-analogue conversion, coupling between channels and bus arbitration belong to the surrounding logic.

The enable is not sampled at every point. During the two fetch start-up steps a low enable cancels the channel at once. While bytes are being played, the enable is only examined when a word ends. A brief low pulse inside one word therefore has no effect. A word request already posted before the channel was cancelled is still honoured, and its word starts free-running playback in interrupt mode. Software can use this as a period timer by acknowledging each interrupt.

Top module: `aud_dma_channel`

## Requirements
- R1: `state_o` shows the sequencer step: 3'b000 idle, 3'b001 first fetch, 3'b101 second start-up step, 3'b010 upper byte playing, 3'b011 lower byte playing. After reset it reads 000, and `sample_o`, `dma_req_o`, `irq_o` and `irq_pend_o` read 0.
- R2: A low `dma_on_i` in step 001 or 101 returns the channel to idle on the next clock edge, and any posted request stays posted.
- R3: While the channel is in step 010 or 011, `dma_on_i` has no effect before that byte's period has expired.
- R4: When the lower byte's period expires, the channel goes idle if `dma_on_i` is low and the interrupt is pending. If `dma_on_i` is low and the interrupt is not pending, it raises an interrupt and plays the next word. If `dma_on_i` is high, it plays the next word and posts a new fetch.
- R5: A low pulse on `dma_on_i` that starts and ends inside one word causes no reload of address or count, no interrupt and no break in playback.
- R6: Raising `dma_on_i` in idle loads the address from `loc_i` and the count from `len_i`, and posts a fetch. The interrupt is raised on the acknowledge of the first word.
- R7: A `len_i` of 0 means 2^16 words: after the first fetch `len_o` reads 16'hFFFF.
- R8: In idle, `sample_o` keeps the last byte played.
- R9: A word acknowledged after the channel has gone idle starts playback (step 010) with an interrupt, and the channel runs on at the period cadence with DMA off.
- R10: The upper byte and then the lower byte of each word appear on `sample_o`, each for `per_i` ticks of `tick_en_i`. The count is reloaded at each byte start.
- R11: Acknowledging a fetch while `len_o` is 1 reloads the address and count from `loc_i`/`len_i` and raises the interrupt.
- R12: `dma_req_o` stays high until `dma_ack_i`. Each acknowledge advances `dma_addr_o` by one and lowers `len_o` by one.
- R13: Every `irq_o` pulse sets `irq_pend_o`, which stays set until `irq_clr_i`. A pulse and a clear in the same cycle leave it set.
- R14: `vol_o` takes `vol_i` at each word start and holds it for the whole word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en_i | input | 1 | Period tick enable |
| dma_on_i | input | 1 | Channel DMA enable level |
| loc_i | input | ADDR_W | Block start word address |
| len_i | input | LEN_W | Block length in words (0 = 2^LEN_W) |
| per_i | input | PER_W | Ticks per byte |
| vol_i | input | VOL_W | Volume setting |
| irq_clr_i | input | 1 | Clears the pending interrupt |
| dma_req_o | output | 1 | Word fetch request |
| dma_addr_o | output | ADDR_W | Word address of the fetch (live pointer) |
| dma_ack_i | input | 1 | Fetched word is valid |
| dma_data_i | input | WORD_W | Fetched sample word |
| state_o | output | 3 | Sequencer step code |
| sample_o | output | WORD_W/2 | Current sample byte |
| vol_o | output | VOL_W | Volume latched for the current word |
| irq_o | output | 1 | One-cycle interrupt pulse |
| irq_pend_o | output | 1 | Interrupt pending flag |
| len_o | output | LEN_W | Remaining word count |

## Verification
The assertions check on every cycle the rules that depend only on the current step. These are the immediate cancel in the start-up steps, the unchanged step while a byte period runs, the continue or idle choice at the word boundary, the held sample in idle, the request held until acknowledge, the pending flag after each pulse, and the address and count reload on start and at block end. Only the bench scenarios can show the effects that build up over a whole word. One is that a short off/on pulse leaves address, count and interrupt count the same as an undisturbed run. Others are that a held clear idles at the next boundary with no new interrupt, that a re-enable from idle restarts from the location register, and that a request left over from a one-cycle enable keeps the channel running as a timer at twice the period.

// File: rtl/aud_seq_pkg.sv
// Shared types for the sample-playback channel sequencer.
// Assumes: step codes are observed outside the block, so their values are fixed.
package aud_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'b000,
        ST_FETCH1 = 3'b001,
        ST_FETCH2 = 3'b101,
        ST_HI     = 3'b010,
        ST_LO     = 3'b011
    } aud_step_e;
endpackage

// File: rtl/aud_period_timer.sv
// Byte period counter: reloads on load_i, counts down on tick_i while above one,
// and flags expiry on a tick while the count is at or below one.
// Assumes: load_i is raised exactly at each byte start.
module aud_period_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [PER_W-1:0] per_i,
    input  logic             tick_i,
    input  logic             run_i,
    output logic             expire_o
);
    localparam logic [PER_W-1:0] ONE = PER_W'(1);

    logic [PER_W-1:0] cnt_q;

    // Reload or count down the byte period.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (load_i)                 cnt_q <= per_i;
        else if (tick_i && cnt_q > ONE)  cnt_q <= cnt_q - ONE;
    end

    assign expire_o = run_i && tick_i && (cnt_q <= ONE);
endmodule

// File: rtl/aud_fetch_ctr.sv
// Live word pointer and remaining-length counter for one channel.
// start_i loads both from the location/length registers and wins over adv_i.
// adv_i (an acknowledged fetch) steps them, or reloads them when one word remains.
// Assumes: a count of zero stands for 2^LEN_W words (wraps through all ones).
module aud_fetch_ctr #(
    parameter int ADDR_W = 18,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              adv_i,
    input  logic [ADDR_W-1:0] loc_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              last_o
);
    localparam logic [LEN_W-1:0] LONE = LEN_W'(1);

    logic [ADDR_W-1:0] ptr_q;
    logic [LEN_W-1:0]  len_q;

    // Load, step or wrap the pointer and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            len_q <= '0;
        end else if (start_i) begin
            ptr_q <= loc_i;
            len_q <= len_i;
        end else if (adv_i) begin
            if (len_q == LONE) begin
                ptr_q <= loc_i;
                len_q <= len_i;
            end else begin
                ptr_q <= ptr_q + ADDR_W'(1);
                len_q <= len_q - LONE;
            end
        end
    end

    assign ptr_o  = ptr_q;
    assign len_o  = len_q;
    assign last_o = (len_q == LONE);

    // R6
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (ptr_o == $past(loc_i)) && (len_o == $past(len_i)));
    // R11
    block_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !start_i && last_o) |=> (ptr_o == $past(loc_i)) && (len_o == $past(len_i)));
    // R12
    fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !start_i && !last_o) |=> (ptr_o == $past(ptr_o) + ADDR_W'(1)));
endmodule

// File: rtl/aud_dma_channel.sv
// One sample-playback channel: fetches words over a req/ack port, plays the
// upper then lower byte for one period each, and loops over the block.
// DMA-off is acted on at once only in the start-up steps. While bytes play,
// it is examined at the word boundary (lower-byte expiry) and idles only when
// the interrupt is pending. A word that arrives after idling starts
// interrupt-mode playback.
// Assumes: dma_ack_i is only meaningful while dma_req_o is high.
module aud_dma_channel
    import aud_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int LEN_W  = 16,
    parameter int PER_W  = 16,
    parameter int VOL_W  = 7,
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en_i,
    input  logic                dma_on_i,
    input  logic [ADDR_W-1:0]   loc_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic [PER_W-1:0]    per_i,
    input  logic [VOL_W-1:0]    vol_i,
    input  logic                irq_clr_i,
    output logic                dma_req_o,
    output logic [ADDR_W-1:0]   dma_addr_o,
    input  logic                dma_ack_i,
    input  logic [WORD_W-1:0]   dma_data_i,
    output logic [2:0]          state_o,
    output logic [WORD_W/2-1:0] sample_o,
    output logic [VOL_W-1:0]    vol_o,
    output logic                irq_o,
    output logic                irq_pend_o,
    output logic [LEN_W-1:0]    len_o
);
    localparam int BYTE_W = WORD_W / 2;

    aud_step_e          state_q, state_d;
    logic [WORD_W-1:0]  word_q, buf_q;
    logic [BYTE_W-1:0]  sample_q;
    logic [VOL_W-1:0]   vol_q;
    logic               rdy_q, req_q, irq_q, pend_q;
    logic               ack_v, expire, last, playing;
    logic               do_load, do_start, post, go_lo, drop_rdy, mode_irq, fire;

    assign ack_v   = dma_ack_i && req_q;
    assign playing = (state_q == ST_HI) || (state_q == ST_LO);

    aud_period_timer #(.PER_W(PER_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (do_load || go_lo),
        .per_i    (per_i),
        .tick_i   (tick_en_i),
        .run_i    (playing),
        .expire_o (expire)
    );

    aud_fetch_ctr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (do_start),
        .adv_i   (ack_v),
        .loc_i   (loc_i),
        .len_i   (len_i),
        .ptr_o   (dma_addr_o),
        .len_o   (len_o),
        .last_o  (last)
    );

    // Next step and the actions it triggers.
    always_comb begin
        state_d  = state_q;
        do_load  = 1'b0;
        do_start = 1'b0;
        post     = 1'b0;
        go_lo    = 1'b0;
        drop_rdy = 1'b0;
        mode_irq = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rdy_q) begin
                    do_load  = 1'b1;
                    mode_irq = 1'b1;
                    state_d  = ST_HI;
                end else if (dma_on_i) begin
                    do_start = 1'b1;
                    post     = 1'b1;
                    state_d  = ST_FETCH1;
                end
            end
            ST_FETCH1: begin
                if (!dma_on_i) state_d = ST_IDLE;
                else if (rdy_q) begin
                    post    = 1'b1;
                    state_d = ST_FETCH2;
                end
            end
            ST_FETCH2: begin
                if (!dma_on_i) state_d = ST_IDLE;
                else begin
                    do_load = 1'b1;
                    state_d = ST_HI;
                end
            end
            ST_HI: begin
                if (expire) begin
                    go_lo   = 1'b1;
                    state_d = ST_LO;
                end
            end
            ST_LO: begin
                if (expire) begin
                    if (!dma_on_i && pend_q) begin
                        drop_rdy = 1'b1;
                        state_d  = ST_IDLE;
                    end else begin
                        do_load = 1'b1;
                        state_d = ST_HI;
                        if (dma_on_i) post     = 1'b1;
                        else          mode_irq = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign fire = (ack_v && ((state_q == ST_FETCH1) || last)) || mode_irq;

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Fetch request, holding buffer and its ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            rdy_q <= 1'b0;
            buf_q <= '0;
        end else begin
            if (post)       req_q <= 1'b1;
            else if (ack_v) req_q <= 1'b0;
            if (ack_v) begin
                buf_q <= dma_data_i;
                rdy_q <= 1'b1;
            end else if (do_load || drop_rdy) begin
                rdy_q <= 1'b0;
            end
        end
    end

    // Output word, current byte and volume.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            sample_q <= '0;
            vol_q    <= '0;
        end else if (do_load) begin
            word_q   <= buf_q;
            sample_q <= buf_q[WORD_W-1:BYTE_W];
            vol_q    <= vol_i;
        end else if (go_lo) begin
            sample_q <= word_q[BYTE_W-1:0];
        end
    end

    // Interrupt pulse and pending flag (set wins over clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            irq_q  <= fire;
            pend_q <= fire || (pend_q && !irq_clr_i);
        end
    end

    assign dma_req_o  = req_q;
    assign state_o    = state_q;
    assign sample_o   = sample_q;
    assign vol_o      = vol_q;
    assign irq_o      = irq_q;
    assign irq_pend_o = pend_q;

    // R2
    startup_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'b001 || state_o == 3'b101) && !dma_on_i) |=> (state_o == 3'b000));
    // R3
    defer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'b010 || state_o == 3'b011) && !expire) |=> (state_o == $past(state_o)));
    // R4
    boundary_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'b011 && expire && (dma_on_i || !irq_pend_o)) |=> (state_o == 3'b010));
    // R4
    boundary_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'b011 && expire && !dma_on_i && irq_pend_o) |=> (state_o == 3'b000));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'b000 && !rdy_q) |=> $stable(sample_o));
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req_o && !dma_ack_i) |=> dma_req_o);
    // R13
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_pend_o);
endmodule

// File: tb/test_aud_dma_channel.sv
`timescale 1ns/1ps
module test_aud_dma_channel;
    localparam int AW = 18, LW = 16, PW = 16, VW = 7, WW = 16;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          tick_en = 1'b1, dma_on = 1'b0, irq_clr = 1'b0;
    logic [AW-1:0] loc = '0;
    logic [LW-1:0] len = '0;
    logic [PW-1:0] per = '0;
    logic [VW-1:0] vol = '0;
    logic          dma_ack = 1'b0;
    logic [WW-1:0] dma_data = '0;
    logic          dma_req_o, irq_o, irq_pend_o;
    logic [AW-1:0] dma_addr_o;
    logic [2:0]    state_o;
    logic [7:0]    sample_o;
    logic [VW-1:0] vol_o;
    logic [LW-1:0] len_o;

    int checks = 0, fails = 0, irq_cnt = 0, cyc = 0;
    bit cmp_on = 1'b0, hold_ack = 1'b0, done = 1'b0;
    int tick_mode = 0, ack_wait = 0;

    always #10 clk = ~clk;

    aud_dma_channel #(.ADDR_W(AW), .LEN_W(LW), .PER_W(PW), .VOL_W(VW), .WORD_W(WW)) i_aud_dma_channel (
        .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en), .dma_on_i(dma_on),
        .loc_i(loc), .len_i(len), .per_i(per), .vol_i(vol), .irq_clr_i(irq_clr),
        .dma_req_o(dma_req_o), .dma_addr_o(dma_addr_o), .dma_ack_i(dma_ack),
        .dma_data_i(dma_data), .state_o(state_o), .sample_o(sample_o),
        .vol_o(vol_o), .irq_o(irq_o), .irq_pend_o(irq_pend_o), .len_o(len_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    logic [2:0]    m_state;
    logic [AW-1:0] m_ptr;
    logic [LW-1:0] m_len;
    logic [PW-1:0] m_cnt;
    logic [WW-1:0] m_buf, m_word;
    logic [7:0]    m_sample;
    logic [VW-1:0] m_vol;
    logic          m_rdy, m_req, m_irq, m_pend;
    always @(posedge clk) begin : model
        logic [2:0]    n_state;
        logic [AW-1:0] n_ptr;
        logic [LW-1:0] n_len;
        logic [PW-1:0] n_cnt;
        logic [WW-1:0] n_buf, n_word;
        logic [7:0]    n_sample;
        logic [VW-1:0] n_vol;
        logic          n_rdy, n_req, ack, tmo, fire, load;
        if (!rst_n) begin
            m_state = 3'b000; m_ptr = '0; m_len = '0; m_cnt = '0; m_buf = '0;
            m_word = '0; m_sample = '0; m_vol = '0; m_rdy = 0; m_req = 0;
            m_irq = 0; m_pend = 0;
        end else begin
            ack  = dma_ack && m_req;
            tmo  = (m_state == 3'b010 || m_state == 3'b011) && tick_en && (m_cnt <= 1);
            fire = ack && (m_state == 3'b001 || m_len == 1);
            load = 0;
            n_state = m_state; n_ptr = m_ptr; n_len = m_len; n_req = m_req; n_rdy = m_rdy;
            n_buf = m_buf; n_word = m_word; n_sample = m_sample; n_vol = m_vol;
            n_cnt = (tick_en && m_cnt > 1) ? m_cnt - 1 : m_cnt;
            if (ack) begin
                n_req = 0;
                if (m_len == 1) begin n_ptr = loc; n_len = len; end
                else begin n_ptr = m_ptr + 1; n_len = m_len - 1; end
            end
            case (m_state)
                3'b000: if (m_rdy) begin load = 1; n_state = 3'b010; fire = 1; end
                        else if (dma_on) begin n_state = 3'b001; n_ptr = loc; n_len = len; n_req = 1; end
                3'b001: if (!dma_on) n_state = 3'b000;
                        else if (m_rdy) begin n_state = 3'b101; n_req = 1; end
                3'b101: if (!dma_on) n_state = 3'b000;
                        else begin load = 1; n_state = 3'b010; end
                3'b010: if (tmo) begin n_state = 3'b011; n_sample = m_word[7:0]; n_cnt = per; end
                3'b011: if (tmo) begin
                            if (!dma_on && m_pend) begin n_state = 3'b000; n_rdy = 0; end
                            else begin
                                load = 1; n_state = 3'b010;
                                if (dma_on) n_req = 1; else fire = 1;
                            end
                        end
                default: n_state = 3'b000;
            endcase
            if (load) begin n_word = m_buf; n_sample = m_buf[15:8]; n_vol = vol; n_cnt = per; n_rdy = 0; end
            if (ack) begin n_buf = dma_data; n_rdy = 1; end
            m_pend = fire || (m_pend && !irq_clr);
            m_irq  = fire;
            m_state = n_state; m_ptr = n_ptr; m_len = n_len; m_cnt = n_cnt; m_buf = n_buf;
            m_word = n_word; m_sample = n_sample; m_vol = n_vol; m_rdy = n_rdy; m_req = n_req;
        end
    end

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(state_o === m_state,     "R1",  "step",    state_o, m_state);
            chk(sample_o === m_sample,   "R10", "sample",  sample_o, m_sample);
            chk(dma_req_o === m_req,     "R12", "request", dma_req_o, m_req);
            chk(dma_addr_o === m_ptr,    "R12", "address", dma_addr_o, m_ptr);
            chk(len_o === m_len,         "R12", "length",  len_o, m_len);
            chk(irq_o === m_irq,         "R6",  "irq",     irq_o, m_irq);
            chk(irq_pend_o === m_pend,   "R13", "pending", irq_pend_o, m_pend);
            chk(vol_o === m_vol,         "R14", "volume",  vol_o, m_vol);
            if (irq_o) irq_cnt++;
        end
    end

    // Memory responder with a fixed three-cycle latency; tick pattern driver.
    always @(negedge clk) begin
        cyc++;
        tick_en <= (tick_mode == 0) ? 1'b1 : (cyc % 3 != 0);
        if (dma_ack) begin
            dma_ack  <= 1'b0;
            ack_wait <= 0;
        end else if (dma_req_o && !hold_ack) begin
            if (ack_wait >= 2) begin
                dma_ack  <= 1'b1;
                dma_data <= {dma_addr_o[7:0] ^ 8'h80, dma_addr_o[7:0] ^ 8'h3C};
            end
            ack_wait <= ack_wait + 1;
        end else begin
            ack_wait <= 0;
        end
    end

    task automatic nstep(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int base, rec_ptr, rec_len, rec_irq, gap;
        logic [7:0] held;
        loc = 18'h00100; len = 16'd4; per = 16'd10; vol = 7'd40;
        nstep(2);
        cmp_on = 1'b1;
        nstep(2);
        rst_n = 1'b1;
        // R1 reset state
        chk(state_o == 3'b000 && sample_o == 0 && !dma_req_o && !irq_o && !irq_pend_o,
            "R1", "reset outputs", {state_o, sample_o}, 0);

        // R6 start from idle
        dma_on = 1'b1;
        nstep(1);
        chk(state_o == 3'b001 && dma_addr_o == 18'h00100 && len_o == 16'd4 && dma_req_o,
            "R6", "start load", dma_addr_o, 18'h00100);
        for (int i = 0; i < 20 && !irq_o; i++) nstep(1);
        chk(irq_cnt == 1 && dma_addr_o == 18'h00101 && len_o == 16'd3,
            "R6", "first-fetch interrupt", irq_cnt, 1);

        // R11 block wrap while playing
        vol = 7'd22;
        nstep(1);
        for (int i = 0; i < 400 && !irq_o; i++) nstep(1);
        chk(irq_o && dma_addr_o == 18'h00100 && len_o == 16'd4,
            "R11", "block wrap reload", dma_addr_o, 18'h00100);

        // R5 / R3 short off/on pulse inside one word
        for (int i = 0; i < 100 && !(state_o == 3'b010 && !dma_req_o); i++) nstep(1);
        rec_ptr = dma_addr_o; rec_len = len_o; rec_irq = irq_cnt;
        dma_on = 1'b0;
        nstep(3);
        chk(state_o == 3'b010 || state_o == 3'b011, "R3", "step during clear",
            state_o, 3'b010);
        dma_on = 1'b1;
        nstep(2);
        chk(dma_addr_o == rec_ptr && len_o == rec_len && irq_cnt == rec_irq,
            "R5", "pulse ignored", dma_addr_o, rec_ptr);
        chk(state_o == 3'b010 || state_o == 3'b011, "R5", "still playing", state_o, 3'b011);

        // R4 / R8 clear held until idle (interrupt pending)
        for (int i = 0; i < 100 && !(state_o == 3'b010 && !dma_req_o); i++) nstep(1);
        rec_irq = irq_cnt; rec_ptr = dma_addr_o;
        dma_on = 1'b0;
        for (int i = 0; i < 200 && state_o != 3'b000; i++) nstep(1);
        chk(state_o == 3'b000 && irq_cnt == rec_irq && dma_addr_o == rec_ptr,
            "R4", "idle at boundary", irq_cnt, rec_irq);
        held = sample_o;
        nstep(30);
        chk(sample_o == held, "R8", "idle holds sample", sample_o, held);

        // R6 / R7 re-enable from idle with length 0
        loc = 18'h00200; len = 16'd0;
        base = irq_cnt;
        dma_on = 1'b1;
        nstep(1);
        chk(state_o == 3'b001 && dma_addr_o == 18'h00200 && len_o == 16'd0,
            "R6", "restart reload", dma_addr_o, 18'h00200);
        for (int i = 0; i < 20 && !irq_o; i++) nstep(1);
        chk(irq_cnt == base + 1 && len_o == 16'hFFFF && dma_addr_o == 18'h00201,
            "R7", "zero length count", len_o, 16'hFFFF);
        tick_mode = 1;
        nstep(90);
        tick_mode = 0;

        // R4 interrupt mode when nothing is pending
        for (int i = 0; i < 100 && !(state_o == 3'b010 && !dma_req_o); i++) nstep(1);
        irq_clr = 1'b1;
        nstep(1);
        irq_clr = 1'b0;
        dma_on = 1'b0;
        base = irq_cnt;
        for (int i = 0; i < 200 && state_o != 3'b000; i++) nstep(1);
        chk(state_o == 3'b000 && irq_cnt == base + 1, "R4", "one interrupt-mode word",
            irq_cnt, base + 1);

        // R2 / R9 brief enable from idle with the fetch left posted
        len = 16'd8; per = 16'd6;
        hold_ack = 1'b1;
        dma_on = 1'b1;
        nstep(1);
        dma_on = 1'b0;
        nstep(1);
        chk(state_o == 3'b000 && dma_req_o, "R2", "start-up cancelled, request kept",
            state_o, 3'b000);
        nstep(3);
        base = irq_cnt;
        hold_ack = 1'b0;
        for (int i = 0; i < 20 && !irq_o; i++) nstep(1);
        chk(state_o == 3'b010 && irq_cnt == base + 1, "R9", "free-run start",
            state_o, 3'b010);
        // R10 cadence: clear each interrupt and time the gap
        irq_clr = 1'b1;
        nstep(1);
        irq_clr = 1'b0;
        gap = 1;
        for (int i = 0; i < 100 && !irq_o; i++) begin nstep(1); gap++; end
        chk(gap == 12, "R10", "period timer cadence", gap, 12);
        chk(state_o == 3'b010, "R9", "still free-running", state_o, 3'b010);
        // R13 set wins over clear in the same cycle, then leave pending -> idle
        chk(irq_pend_o, "R13", "pending after pulse", irq_pend_o, 1);
        for (int i = 0; i < 40 && state_o != 3'b000; i++) nstep(1);
        chk(state_o == 3'b000, "R4", "free-run ends when pending", state_o, 3'b000);
        nstep(5);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule